// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block arbitrates among eight interrupt request lines. It latches rising edges of the request inputs into a pending register, holds a mask and an in-service register, and keeps a three-bit pointer to the pin that currently has the lowest priority. Every cycle it scans the pins, starting just above that pointer and wrapping round, and offers the first pending, unmasked pin that nothing already in service outranks. The consumer takes that pin with a valid/ready handshake. Taking a pin moves it from pending to in service.

Software-side control arrives as a decoded command strobe. Its three flags are end-of-interrupt, rotate and select, and it carries a three-bit level. With these the host ends service on the top in-service pin or on a named pin, optionally hands lowest priority to the pin just ended, or moves the lowest-priority pointer directly. Three mode levels alter the scan. Special mask mode lets the mask alone decide which pins fire. Nested-cascade mode stops in-service pin 2 from blocking other pins. Auto-end mode skips the in-service step on acceptance.

The offer (`out_valid`, `out_pin`) is combinational from the registers and mode pins. Handshake rules: an offer is taken in any cycle where `out_valid` and `out_ready` are both high, and the pin taken is the one shown in that cycle. The offer is not held while it waits. A newly latched request, a mask change or a mode change can replace the pin or withdraw the offer before `out_ready` arrives. A registered copy of the offer is provided one cycle later.

Top module: `irq_prio_resolver`

## Requirements
- R1: A synchronous reset clears the pending, in-service and mask registers and sets the lowest-priority pointer to 7, so no offer is made.
- R2: The scan starts at (pointer+1) mod 8 and wraps through all eight pins. The first pin found wins. After reset, pin 0 ranks highest.
- R3: A pin is eligible only when its pending bit is set and its mask bit is clear. The scan ends with no offer at the first pin whose in-service bit is set. With no offer, `out_pin` reads 0. `mask_we` loads `mask_in` into the mask, where bit n masks pin n.
- R4: While `smm_en` is high, the in-service register plays no part in choosing the offer.
- R5: While `sfnm_en` is high, in-service bit 2 does not block the scan.
- R6: A command with `cmd_eoi`=1 and `cmd_sel`=0 clears the highest-priority set in-service bit. While `smm_en` is high, it skips in-service bits whose mask bit is set. If no bit qualifies, nothing changes.
- R7: A command with `cmd_eoi`=1 and `cmd_sel`=1 clears in-service bit `cmd_lvl`. When `cmd_rot`=1, the pin that was ended (specific or non-specific) becomes the lowest-priority pin.
- R8: A command with `cmd_sel`=1, `cmd_rot`=1 and `cmd_eoi`=0 loads the pointer from `cmd_lvl` and leaves the in-service register unchanged. With `cmd_sel`=1 and `cmd_rot`=0, a command without end-of-interrupt changes neither.
- R9: On acceptance, the taken pin's pending bit is cleared unless its request input is still high, and its in-service bit is set when `aeoi_en` is low.
- R10: With `aeoi_en` high, acceptance leaves the in-service register alone. If the stored rotate flag is set, it makes the taken pin the lowest-priority pin.
- R11: A pending bit is set by a rising edge on its request input. A falling edge does not clear it.
- R12: `res_valid_q`/`res_pin_q` show the offer that was present at the previous clock edge.
- R13: Every command stores its `cmd_rot` flag, and the stored flag governs auto-end rotation until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Request input lines, one per pin |
| mask_we | input | 1 | Load mask register |
| mask_in | input | 8 | New mask value |
| smm_en | input | 1 | Special mask mode |
| sfnm_en | input | 1 | Nested-cascade mode (ignore in-service pin 2) |
| aeoi_en | input | 1 | Auto-end mode |
| cmd_valid | input | 1 | Command strobe |
| cmd_eoi | input | 1 | Command: end of interrupt |
| cmd_rot | input | 1 | Command: rotate |
| cmd_sel | input | 1 | Command: use cmd_lvl |
| cmd_lvl | input | 3 | Command pin number |
| out_valid | output | 1 | An eligible pin is offered |
| out_ready | input | 1 | Consumer accepts the offered pin |
| out_pin | output | 3 | Offered pin |
| res_valid_q | output | 1 | Registered offer valid |
| res_pin_q | output | 3 | Registered offer pin |
| irr_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |
| lowprio_o | output | 3 | Lowest-priority pointer |

## Verification
The bench goes after the wrap of the scan past pin 7. A design that scans from pin 0 regardless of the pointer would offer pin 1 where pin 6 is due. It checks that an in-service pin blocks lower pins, and that a design which only skips that pin would raise a request it must hold back. It covers the two modes that relax blocking, where a wrong design keeps the offer low. It also covers a masked in-service bit under special mask mode, which a careless non-specific end would clear. Acceptance is run both with the request line still high and after it has dropped, and in auto-end mode with the stored rotate flag both clear and set. These cases catch a design that clears the pending bit unconditionally or rotates on the wrong flag.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Decoded command flags presented with the command strobe.
  typedef struct packed {
    logic eoi;
    logic rot;
    logic sel;
  } irq_cmd_t;
endpackage

// File: rtl/irq_rot_scan.sv
// Rotating priority scan: walks pins from low+1 upward with wrap,
// stops at the first blocking pin, reports the first eligible pin.
module irq_rot_scan #(
  parameter int NPIN = 8,
  localparam int PW = $clog2(NPIN)
) (
  input  logic [PW-1:0]   low,
  input  logic [NPIN-1:0] elig,
  input  logic [NPIN-1:0] block,
  output logic            hit,
  output logic [PW-1:0]   pin
);
  logic stop;

  always_comb begin
    hit  = 1'b0;
    pin  = '0;
    stop = 1'b0;
    for (int k = 0; k < NPIN; k++) begin
      int unsigned p;
      p = (int'(low) + 1 + k) % NPIN;
      if (!stop) begin
        if (block[p]) begin
          stop = 1'b1;
        end else if (elig[p]) begin
          hit  = 1'b1;
          pin  = PW'(p);
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_req_capture.sv
// Pending register: set on rising request edge, cleared on acceptance
// only when the line has already dropped.
module irq_req_capture #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] req_in,
  input  logic [NPIN-1:0] take_oh,
  output logic [NPIN-1:0] pend
);
  logic [NPIN-1:0] req_prev;
  logic [NPIN-1:0] rise;
  logic [NPIN-1:0] drop;

  assign rise = req_in & ~req_prev;
  assign drop = take_oh & ~req_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= '0;
      pend     <= '0;
    end else begin
      req_prev <= req_in;
      pend     <= (pend & ~drop) | rise;
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int CASCADE_PIN = 2,
  localparam int PW = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] req_in,
  input  logic            mask_we,
  input  logic [NPIN-1:0] mask_in,
  input  logic            smm_en,
  input  logic            sfnm_en,
  input  logic            aeoi_en,
  input  logic            cmd_valid,
  input  logic            cmd_eoi,
  input  logic            cmd_rot,
  input  logic            cmd_sel,
  input  logic [PW-1:0]   cmd_lvl,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PW-1:0]   out_pin,
  output logic            res_valid_q,
  output logic [PW-1:0]   res_pin_q,
  output logic [NPIN-1:0] irr_o,
  output logic [NPIN-1:0] isr_o,
  output logic [PW-1:0]   lowprio_o
);
  localparam logic [NPIN-1:0] CASC_BIT = NPIN'(1) << CASCADE_PIN;
  localparam logic [PW-1:0]   LOW_RST  = PW'(NPIN - 1);

  irq_cmd_t        cmd;
  logic [NPIN-1:0] isr_q;
  logic [NPIN-1:0] imr_q;
  logic [PW-1:0]   low_q;
  logic            rot_q;
  logic [NPIN-1:0] pend;
  logic [NPIN-1:0] svc_block;
  logic [NPIN-1:0] eoi_cand;
  logic            eoi_hit;
  logic [PW-1:0]   eoi_pin;
  logic            accept;
  logic [NPIN-1:0] take_oh;
  logic            tgt_hit;
  logic [PW-1:0]   tgt_pin;
  logic [NPIN-1:0] eoi_clr;
  logic [NPIN-1:0] isr_set;

  assign cmd = '{eoi: cmd_eoi, rot: cmd_rot, sel: cmd_sel};

  // In-service view used for blocking the request scan.
  always_comb begin
    svc_block = isr_q;
    if (sfnm_en) svc_block = svc_block & ~CASC_BIT;
    if (smm_en)  svc_block = '0;
  end

  assign eoi_cand = smm_en ? (isr_q & ~imr_q) : isr_q;

  irq_rot_scan #(.NPIN(NPIN)) u_req_scan (
    .low  (low_q),
    .elig (pend & ~imr_q),
    .block(svc_block),
    .hit  (out_valid),
    .pin  (out_pin)
  );

  irq_rot_scan #(.NPIN(NPIN)) u_eoi_scan (
    .low  (low_q),
    .elig (eoi_cand),
    .block('0),
    .hit  (eoi_hit),
    .pin  (eoi_pin)
  );

  irq_req_capture #(.NPIN(NPIN)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .req_in (req_in),
    .take_oh(take_oh),
    .pend   (pend)
  );

  assign accept  = out_valid && out_ready;
  assign take_oh = accept ? (NPIN'(1) << out_pin) : '0;
  assign isr_set = aeoi_en ? '0 : take_oh;

  always_comb begin
    if (cmd.sel) begin
      tgt_hit = 1'b1;
      tgt_pin = cmd_lvl;
    end else begin
      tgt_hit = eoi_hit;
      tgt_pin = eoi_pin;
    end
  end

  assign eoi_clr = (cmd_valid && cmd.eoi && tgt_hit) ? (NPIN'(1) << tgt_pin) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q       <= '0;
      imr_q       <= '0;
      low_q       <= LOW_RST;
      rot_q       <= 1'b0;
      res_valid_q <= 1'b0;
      res_pin_q   <= '0;
    end else begin
      isr_q       <= (isr_q | isr_set) & ~eoi_clr;
      res_valid_q <= out_valid;
      res_pin_q   <= out_pin;
      if (mask_we) imr_q <= mask_in;
      if (cmd_valid) rot_q <= cmd.rot;
      if (cmd_valid && cmd.eoi && tgt_hit && cmd.rot) begin
        low_q <= tgt_pin;
      end else if (cmd_valid && !cmd.eoi && cmd.sel && cmd.rot) begin
        low_q <= cmd_lvl;
      end else if (accept && aeoi_en && rot_q) begin
        low_q <= out_pin;
      end
    end
  end

  assign irr_o     = pend;
  assign isr_o     = isr_q;
  assign lowprio_o = low_q;
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
  parameter int NPIN = 8,
  localparam int PW = $clog2(NPIN)
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            out_ready,
  input logic [PW-1:0]   out_pin,
  input logic [NPIN-1:0] irr,
  input logic [NPIN-1:0] isr,
  input logic [NPIN-1:0] imr,
  input logic [PW-1:0]   lowprio,
  input logic            smm_en,
  input logic            aeoi_en,
  input logic            cmd_valid,
  input logic            cmd_eoi,
  input logic            cmd_rot,
  input logic            cmd_sel,
  input logic [PW-1:0]   cmd_lvl
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lowprio == PW'(NPIN - 1) && isr == '0)); // R1

  AST_OFFER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (irr[out_pin] && !imr[out_pin])); // R3

  AST_SMM_FIRES: assert property (@(posedge clk) disable iff (rst)
    (smm_en && (irr & ~imr) != '0) |-> out_valid); // R4

  AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_eoi && cmd_sel && !(out_valid && out_ready))
      |=> !isr[$past(cmd_lvl)]); // R7

  AST_PRIO_SET: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_eoi && cmd_sel && cmd_rot && !(out_valid && out_ready))
      |=> (lowprio == $past(cmd_lvl) && $stable(isr))); // R8

  AST_ACCEPT_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !aeoi_en && !cmd_valid)
      |=> isr[$past(out_pin)]); // R9

  AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && aeoi_en && !cmd_valid && !isr[out_pin])
      |=> !isr[$past(out_pin)]); // R10
endmodule

bind irq_prio_resolver irq_prio_checker #(.NPIN(NPIN)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_pin  (out_pin),
  .irr      (irr_o),
  .isr      (isr_o),
  .imr      (imr_q),
  .lowprio  (lowprio_o),
  .smm_en   (smm_en),
  .aeoi_en  (aeoi_en),
  .cmd_valid(cmd_valid),
  .cmd_eoi  (cmd_eoi),
  .cmd_rot  (cmd_rot),
  .cmd_sel  (cmd_sel),
  .cmd_lvl  (cmd_lvl)
);

// File: tb/tb_irq_prio_resolver.sv
module tb_irq_prio_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int K_OUT = 0, K_IRR = 1, K_ISR = 2, K_LOW = 3, K_RES = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_in = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_in = '0;
  logic       smm_en = 1'b0, sfnm_en = 1'b0, aeoi_en = 1'b0;
  logic       cmd_valid = 1'b0, cmd_eoi = 1'b0, cmd_rot = 1'b0, cmd_sel = 1'b0;
  logic [2:0] cmd_lvl = '0;
  logic       out_valid, out_ready = 1'b0;
  logic [2:0] out_pin;
  logic       res_valid_q;
  logic [2:0] res_pin_q;
  logic [7:0] irr_o, isr_o;
  logic [2:0] lowprio_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int         kind_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  irq_prio_resolver dut (
    .clk(clk), .rst(rst), .req_in(req_in), .mask_we(mask_we), .mask_in(mask_in),
    .smm_en(smm_en), .sfnm_en(sfnm_en), .aeoi_en(aeoi_en),
    .cmd_valid(cmd_valid), .cmd_eoi(cmd_eoi), .cmd_rot(cmd_rot), .cmd_sel(cmd_sel),
    .cmd_lvl(cmd_lvl), .out_valid(out_valid), .out_ready(out_ready), .out_pin(out_pin),
    .res_valid_q(res_valid_q), .res_pin_q(res_pin_q), .irr_o(irr_o), .isr_o(isr_o),
    .lowprio_o(lowprio_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Monitor: pops expectations at the falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      while (kind_q.size() > 0) begin
        int k;
        logic [7:0] e, a;
        string t;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        case (k)
          K_OUT:   a = {4'b0, out_valid, out_pin};
          K_IRR:   a = irr_o;
          K_ISR:   a = isr_o;
          K_LOW:   a = {5'b0, lowprio_o};
          default: a = {4'b0, res_valid_q, res_pin_q};
        endcase
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] offer(input bit v, input int p);
    return v ? 8'(8 + p) : 8'h00;
  endfunction

  task automatic expect_item(input int k, input logic [7:0] e, input string t);
    kind_q.push_back(k);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    out_ready = 1'b0;
    mask_we   = 1'b0;
  endtask

  task automatic go();
    @(negedge clk);
    #1;
  endtask

  task automatic do_cmd(input bit e, input bit r, input bit s, input logic [2:0] l);
    go();
    cmd_valid = 1'b1; cmd_eoi = e; cmd_rot = r; cmd_sel = s; cmd_lvl = l;
    tick();
  endtask

  task automatic do_ack();
    go();
    out_ready = 1'b1;
    tick();
  endtask

  task automatic set_mask(input logic [7:0] m);
    go();
    mask_we = 1'b1; mask_in = m;
    tick();
  endtask

  task automatic set_req(input logic [7:0] r);
    go();
    req_in = r;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    go();
    rst = 1'b0;
    tick();
    expect_item(K_IRR, 8'h00, "R1 irr");
    expect_item(K_ISR, 8'h00, "R1 isr");
    expect_item(K_LOW, 8'd7, "R1 lowprio");
    expect_item(K_OUT, offer(0, 0), "R1 no offer");

    set_req(8'h28);
    expect_item(K_IRR, 8'h28, "R11 rising edge latch");
    expect_item(K_OUT, offer(1, 3), "R2 pin3 before pin5");

    do_ack();
    expect_item(K_ISR, 8'h08, "R9 isr set");
    expect_item(K_IRR, 8'h28, "R9 line high keeps pending");
    expect_item(K_OUT, offer(0, 0), "R3 in-service blocks lower");

    set_req(8'h00);
    expect_item(K_IRR, 8'h28, "R11 falling edge ignored");

    do_cmd(1, 0, 0, 0);
    expect_item(K_ISR, 8'h00, "R6 non-specific end");
    expect_item(K_OUT, offer(1, 3), "R6 pin3 offered again");

    do_ack();
    expect_item(K_IRR, 8'h20, "R9 line low clears pending");
    expect_item(K_ISR, 8'h08, "R9 isr set again");

    do_cmd(1, 1, 1, 3);
    expect_item(K_ISR, 8'h00, "R7 specific end");
    expect_item(K_LOW, 8'd3, "R7 rotate on end");
    expect_item(K_OUT, offer(1, 5), "R2 scan after rotation");

    set_mask(8'h20);
    expect_item(K_OUT, offer(0, 0), "R3 masked pin");
    set_mask(8'h00);
    expect_item(K_OUT, offer(1, 5), "R3 unmasked pin");

    do_cmd(0, 1, 1, 5);
    expect_item(K_LOW, 8'd5, "R8 priority set");
    expect_item(K_ISR, 8'h00, "R8 isr untouched");

    set_req(8'h42);
    expect_item(K_IRR, 8'h62, "R11 new edges");
    expect_item(K_OUT, offer(1, 6), "R2 wrap order from 6");

    do_cmd(0, 0, 1, 0);
    expect_item(K_LOW, 8'd5, "R8 select without rotate");

    do_ack();
    expect_item(K_ISR, 8'h40, "R9 pin6 in service");
    expect_item(K_OUT, offer(0, 0), "R3 pin6 blocks");

    go();
    smm_en = 1'b1;
    expect_item(K_OUT, offer(1, 6), "R4 mask mode ignores isr");

    set_mask(8'h40);
    expect_item(K_OUT, offer(1, 1), "R4 wrap to pin1");

    do_cmd(1, 0, 0, 0);
    expect_item(K_ISR, 8'h40, "R6 masked isr skipped");

    go();
    smm_en = 1'b0;
    set_mask(8'h00);
    do_cmd(1, 0, 0, 0);
    expect_item(K_ISR, 8'h00, "R6 end after mask mode");
    expect_item(K_OUT, offer(1, 6), "R2 pin6 again");

    do_cmd(0, 1, 1, 7);
    expect_item(K_OUT, offer(1, 1), "R8 back to default order");

    set_req(8'h04);
    expect_item(K_IRR, 8'h66, "R11 pin2 edge");

    do_ack();
    expect_item(K_IRR, 8'h64, "R9 pin1 dropped");
    expect_item(K_OUT, offer(0, 0), "R3 pin1 blocks");

    do_cmd(1, 0, 0, 0);
    expect_item(K_OUT, offer(1, 2), "R6 pin2 next");

    do_ack();
    expect_item(K_ISR, 8'h04, "R9 pin2 in service");
    expect_item(K_OUT, offer(0, 0), "R5 blocked without mode");

    go();
    sfnm_en = 1'b1;
    expect_item(K_OUT, offer(1, 2), "R5 cascade pin not blocking");
    go();
    sfnm_en = 1'b0;
    expect_item(K_OUT, offer(0, 0), "R5 mode off blocks again");

    do_cmd(1, 0, 0, 0);
    go();
    aeoi_en = 1'b1;
    do_ack();
    expect_item(K_ISR, 8'h00, "R10 no isr in auto mode");
    expect_item(K_LOW, 8'd7, "R13 rotate flag clear");
    expect_item(K_RES, offer(1, 2), "R12 registered offer");

    set_req(8'h00);
    do_cmd(0, 1, 0, 0);
    expect_item(K_LOW, 8'd7, "R13 rotate only stores flag");

    do_ack();
    expect_item(K_IRR, 8'h60, "R9 pin2 pending cleared");
    expect_item(K_LOW, 8'd2, "R10 rotate on auto accept");
    expect_item(K_OUT, offer(1, 5), "R2 scan from 3");
    expect_item(K_RES, offer(1, 2), "R12 previous offer");

    go();
    tick();
    expect_item(K_RES, offer(1, 5), "R12 follows offer");

    go();
    go();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule